// File: doc/BRIEF.md
# Snooping Write-Back Cache Coherence Controller

This block sits beside one small direct-mapped write-back cache in a shared-bus multiprocessor and keeps its lines coherent with the other caches on that bus. It uses a write-invalidate protocol. Each line is Invalid (it holds nothing), Shared (a clean copy that can only be read) or Exclusive (the only copy, writable and dirty). Every line holds one data word, and the upper address bits are its tag.

Two engines work on the same line-state array. The processor engine serves loads and stores. Hits complete locally. A miss raises a bus request and places its transaction only in a granted cycle. If the indexed line holds a dirty block with another tag, that victim is written back first, as a bus tenure of its own. The snoop engine watches the other caches' commands every cycle. On a tag hit it drops or downgrades the local copy, and it hands over dirty data in the same cycle so that memory can be bypassed and updated. A request that is waiting for the bus decides what to issue only at grant time, so any snoop that lands in the meantime is taken into account. The system above the block supplies the bus arbitration and the memory.

Top module: `snoop_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid, no bus request is raised, and the first access to any address misses.
- R2: A read to an Invalid line issues one read miss (bus command 2'b01) carrying the request address, and the line becomes Shared. Later reads to that address hit.
- R3: A write to an Invalid or Shared line issues one write miss (bus command 2'b10) carrying the request address and write data, and the line becomes Exclusive. A write to a Shared line never completes locally.
- R4: A read hit (Shared or Exclusive) or a write hit (Exclusive) raises cpu_done_o in the request cycle with cpu_stall_o low. It raises no bus request, and a read hit returns the stored word on cpu_rdata_o.
- R5: When the line index is held Exclusive under another tag, the controller first issues a write-back (bus command 2'b11) carrying the victim's address and data, and then the miss. A clean victim is dropped without any bus command.
- R6: A snooped write miss that hits a Shared line makes it Invalid, so the next local read to it misses.
- R7: A snooped read miss that hits an Exclusive line raises snp_flush_o in that cycle, with the dirty word on snp_data_o, and the line becomes Shared.
- R8: A snooped write miss that hits an Exclusive line raises snp_flush_o with the dirty word, and the line becomes Invalid.
- R9: A bus command appears only in a cycle where bus_req_o and bus_gnt_i are both high, and no line changes for a miss before that cycle. cpu_stall_o stays high from the miss cycle until cpu_done_o, which rises one cycle after the miss is placed on the bus.
- R10: A snoop to the same line index takes priority over the processor in that cycle. A request waiting for the bus is re-evaluated at grant against the line as the snoop left it, so a victim that a snoop has already flushed is not written back.
- R11: Read-miss data is taken from bus_fill_i in the cycle the read miss is placed on the bus, and it is returned on cpu_rdata_o with cpu_done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until cpu_done_o |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | ADDR_W | Request address: tag above, index in the low IDX_W bits |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_stall_o | output | 1 | Request is waiting on a miss or a snoop |
| cpu_done_o | output | 1 | Request completes in this cycle |
| cpu_rdata_o | output | DATA_W | Load data, valid with cpu_done_o |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_cmd_o | output | 2 | 00 idle, 01 read miss, 10 write miss, 11 write-back |
| bus_addr_o | output | ADDR_W | Address of the placed command |
| bus_data_o | output | DATA_W | Write-back or write-miss data |
| bus_fill_i | input | DATA_W | Fill word for an own read miss, same cycle |
| snp_cmd_i | input | 2 | Command another cache places on the bus |
| snp_addr_i | input | ADDR_W | Address of that command |
| snp_flush_o | output | 1 | Dirty copy supplied for the snooped command |
| snp_data_o | output | DATA_W | Supplied dirty word |

## Verification
Results fall into three kinds. A hit completes within its own cycle. A miss places its command in the granted cycle and raises cpu_done_o one cycle later. A flush answers in the same cycle as the snooped command. Inputs change shortly after a rising edge and all outputs are sampled at the falling edge. For each operation the bench logs every bus command and flush it sees at the falling edges, until cpu_done_o. It then compares that log, whether the operation hit, and the read data against a hand-derived table for a two-cache write/read/write sequence. Directed cases hold one cache's grant to provoke the snoop-while-waiting race, and they re-apply reset.

// File: rtl/scc_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the snooping coherence controller.
// Assumes a 2-bit bus command field decoded by every cache on the bus.
package scc_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE   = 2'b00,
        CMD_RDMISS = 2'b01,
        CMD_WRMISS = 2'b10,
        CMD_WBACK  = 2'b11
    } bus_cmd_e;

    typedef enum logic [1:0] {
        LN_INV = 2'b00,
        LN_SHR = 2'b01,
        LN_EXC = 2'b10
    } line_st_e;

    typedef enum logic [1:0] {
        PC_IDLE = 2'b00,
        PC_ARB  = 2'b01,
        PC_DONE = 2'b10
    } pc_state_e;
endpackage

// File: rtl/scc_line_store.sv
`timescale 1ns/1ps
// Line array: state, tag and one data word per direct-mapped line.
// Two read ports (processor, snoop) and two write ports. A snoop state
// write wins over a processor write to the same line in the same cycle.
// Assumes the processor side never writes a line a snoop is updating.
module scc_line_store
    import scc_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  p_idx,
    output line_st_e          p_st,
    output logic [TAG_W-1:0]  p_tag,
    output logic [DATA_W-1:0] p_data,
    input  logic [IDX_W-1:0]  s_idx,
    output line_st_e          s_st,
    output logic [TAG_W-1:0]  s_tag,
    output logic [DATA_W-1:0] s_data,
    input  logic              s_we,
    input  line_st_e          s_nst,
    input  logic              p_we,
    input  line_st_e          p_nst,
    input  logic [TAG_W-1:0]  p_ntag,
    input  logic [DATA_W-1:0] p_ndata
);
    localparam int NLINES = 1 << IDX_W;

    line_st_e          st_q  [NLINES];
    logic [TAG_W-1:0]  tag_q [NLINES];
    logic [DATA_W-1:0] dat_q [NLINES];

    // Line state: reset to Invalid, snoop update before processor update.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NLINES; i++) begin
            if (!rst_n)
                st_q[i] <= LN_INV;
            else if (s_we && s_idx == IDX_W'(i))
                st_q[i] <= s_nst;
            else if (p_we && p_idx == IDX_W'(i))
                st_q[i] <= p_nst;
        end
    end

    // Tag and data: written only by the processor side.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NLINES; i++) begin
            if (p_we && p_idx == IDX_W'(i) && !(s_we && s_idx == IDX_W'(i))) begin
                tag_q[i] <= p_ntag;
                dat_q[i] <= p_ndata;
            end
        end
    end

    assign p_st   = st_q[p_idx];
    assign p_tag  = tag_q[p_idx];
    assign p_data = dat_q[p_idx];
    assign s_st   = st_q[s_idx];
    assign s_tag  = tag_q[s_idx];
    assign s_data = dat_q[s_idx];
endmodule

// File: rtl/scc_snoop_unit.sv
`timescale 1ns/1ps
// Snoop engine: decides from a foreign bus command and the indexed line
// whether the local copy is dropped, downgraded or flushed.
// Assumes write-back commands from others never touch local copies.
module scc_snoop_unit
    import scc_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  bus_cmd_e          cmd,
    input  logic [TAG_W-1:0]  tag,
    input  line_st_e          st,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              hit,
    output logic              upd,
    output line_st_e          nst,
    output logic              flush,
    output logic [DATA_W-1:0] fdata
);
    // Transition table of the snooped side.
    always_comb begin
        hit   = (cmd == CMD_RDMISS || cmd == CMD_WRMISS) && st != LN_INV && ln_tag == tag;
        upd   = 1'b0;
        nst   = st;
        flush = 1'b0;
        if (hit) begin
            if (cmd == CMD_WRMISS) begin
                upd   = 1'b1;
                nst   = LN_INV;
                flush = (st == LN_EXC);
            end else if (st == LN_EXC) begin
                upd   = 1'b1;
                nst   = LN_SHR;
                flush = 1'b1;
            end
        end
        fdata = flush ? ln_data : '0;
    end
endmodule

// File: rtl/scc_proc_ctrl.sv
`timescale 1ns/1ps
// Processor engine: hit service, bus arbitration, victim write-back and
// miss issue. Decides what to issue in the granted cycle only, from the
// line as it stands then (restart after snoops). Assumes the processor
// holds its request stable until cpu_done.
module scc_proc_ctrl
    import scc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_stall,
    output logic                    cpu_done,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic [IDX_W-1:0]        lk_idx,
    input  line_st_e                ln_st,
    input  logic [ADDR_W-IDX_W-1:0] ln_tag,
    input  logic [DATA_W-1:0]       ln_data,
    input  logic                    snp_block,
    output logic                    bus_req,
    input  logic                    bus_gnt,
    output bus_cmd_e                bus_cmd,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [DATA_W-1:0]       bus_data,
    input  logic [DATA_W-1:0]       bus_fill,
    output logic                    wr_en,
    output line_st_e                wr_st,
    output logic [ADDR_W-IDX_W-1:0] wr_tag,
    output logic [DATA_W-1:0]       wr_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    pc_state_e         state_q, state_d;
    logic              rq_we;
    logic [ADDR_W-1:0] rq_addr;
    logic [DATA_W-1:0] rq_wdata, rdata_q;
    logic              latch, fill_cap;

    logic              cur_we;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic [TAG_W-1:0]  cur_tag;
    logic              tag_hit, is_hit, victim_dirty;

    // Working request: live inputs while idle, latched copy otherwise.
    always_comb begin
        cur_we    = (state_q == PC_IDLE) ? cpu_we    : rq_we;
        cur_addr  = (state_q == PC_IDLE) ? cpu_addr  : rq_addr;
        cur_wdata = (state_q == PC_IDLE) ? cpu_wdata : rq_wdata;
        cur_tag   = cur_addr[ADDR_W-1:IDX_W];
        lk_idx    = cur_addr[IDX_W-1:0];
    end

    // Hit and victim classification against the indexed line.
    always_comb begin
        tag_hit      = ln_st != LN_INV && ln_tag == cur_tag;
        is_hit       = tag_hit && (!cur_we || ln_st == LN_EXC);
        victim_dirty = ln_st == LN_EXC && ln_tag != cur_tag;
    end

    // Next state, bus outputs and line update of the processor side.
    always_comb begin
        state_d   = state_q;
        bus_req   = 1'b0;
        bus_cmd   = CMD_IDLE;
        bus_addr  = '0;
        bus_data  = '0;
        cpu_stall = 1'b0;
        cpu_done  = 1'b0;
        wr_en     = 1'b0;
        wr_st     = ln_st;
        wr_tag    = ln_tag;
        wr_data   = ln_data;
        latch     = 1'b0;
        fill_cap  = 1'b0;
        unique case (state_q)
            PC_IDLE: begin
                if (cpu_req) begin
                    if (snp_block) begin
                        cpu_stall = 1'b1;
                    end else if (is_hit) begin
                        cpu_done = 1'b1;
                        if (cur_we) begin
                            wr_en   = 1'b1;
                            wr_data = cur_wdata;
                        end
                    end else begin
                        cpu_stall = 1'b1;
                        latch     = 1'b1;
                        state_d   = PC_ARB;
                    end
                end
            end
            PC_ARB: begin
                cpu_stall = 1'b1;
                bus_req   = 1'b1;
                if (bus_gnt && !snp_block) begin
                    wr_en = 1'b1;
                    if (victim_dirty) begin
                        bus_cmd  = CMD_WBACK;
                        bus_addr = {ln_tag, lk_idx};
                        bus_data = ln_data;
                        wr_st    = LN_INV;
                    end else begin
                        bus_cmd  = cur_we ? CMD_WRMISS : CMD_RDMISS;
                        bus_addr = cur_addr;
                        wr_tag   = cur_tag;
                        if (cur_we) begin
                            bus_data = cur_wdata;
                            wr_st    = LN_EXC;
                            wr_data  = cur_wdata;
                        end else begin
                            wr_st    = LN_SHR;
                            wr_data  = bus_fill;
                            fill_cap = 1'b1;
                        end
                        state_d = PC_DONE;
                    end
                end
            end
            PC_DONE: begin
                cpu_done = 1'b1;
                state_d  = PC_IDLE;
            end
            default: state_d = PC_IDLE;
        endcase
    end

    // Control state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PC_IDLE;
        else        state_q <= state_d;
    end

    // Request copy on a miss, fill word on a read-miss issue.
    always_ff @(posedge clk) begin
        if (latch) begin
            rq_we    <= cpu_we;
            rq_addr  <= cpu_addr;
            rq_wdata <= cpu_wdata;
        end
        if (fill_cap) rdata_q <= bus_fill;
    end

    assign cpu_rdata = (state_q == PC_DONE) ? rdata_q : ln_data;
endmodule

// File: rtl/snoop_coherence_ctrl.sv
`timescale 1ns/1ps
// Per-cache coherence controller (three-state write-invalidate, write-back).
// Joins the line store, the processor engine and the snoop engine. A snoop
// to the processor's line index blocks the processor side for that cycle.
// Assumes an atomic bus: snoop input and own grant are never active together.
module snoop_coherence_ctrl
    import scc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              cpu_stall_o,
    output logic              cpu_done_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic [1:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    input  logic [DATA_W-1:0] bus_fill_i,
    input  logic [1:0]        snp_cmd_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    output logic              snp_flush_o,
    output logic [DATA_W-1:0] snp_data_o
);
    localparam int TAG_W = ADDR_W - IDX_W;

    bus_cmd_e          snp_cmd, own_cmd;
    logic [IDX_W-1:0]  lk_idx, s_idx;
    line_st_e          p_st, s_st, s_nst, wr_st;
    logic [TAG_W-1:0]  p_tag, s_tag, wr_tag;
    logic [DATA_W-1:0] p_data, s_data, wr_data;
    logic              s_hit, s_upd, wr_en, snp_block;

    assign snp_cmd   = bus_cmd_e'(snp_cmd_i);
    assign s_idx     = snp_addr_i[IDX_W-1:0];
    assign snp_block = (snp_cmd == CMD_RDMISS || snp_cmd == CMD_WRMISS) && s_idx == lk_idx;
    assign bus_cmd_o = own_cmd;

    scc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .p_idx(lk_idx), .p_st(p_st), .p_tag(p_tag), .p_data(p_data),
        .s_idx(s_idx), .s_st(s_st), .s_tag(s_tag), .s_data(s_data),
        .s_we(s_upd), .s_nst(s_nst),
        .p_we(wr_en), .p_nst(wr_st), .p_ntag(wr_tag), .p_ndata(wr_data)
    );

    scc_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .cmd(snp_cmd), .tag(snp_addr_i[ADDR_W-1:IDX_W]),
        .st(s_st), .ln_tag(s_tag), .ln_data(s_data),
        .hit(s_hit), .upd(s_upd), .nst(s_nst),
        .flush(snp_flush_o), .fdata(snp_data_o)
    );

    scc_proc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_proc (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req_i), .cpu_we(cpu_we_i), .cpu_addr(cpu_addr_i), .cpu_wdata(cpu_wdata_i),
        .cpu_stall(cpu_stall_o), .cpu_done(cpu_done_o), .cpu_rdata(cpu_rdata_o),
        .lk_idx(lk_idx), .ln_st(p_st), .ln_tag(p_tag), .ln_data(p_data),
        .snp_block(snp_block),
        .bus_req(bus_req_o), .bus_gnt(bus_gnt_i), .bus_cmd(own_cmd),
        .bus_addr(bus_addr_o), .bus_data(bus_data_o), .bus_fill(bus_fill_i),
        .wr_en(wr_en), .wr_st(wr_st), .wr_tag(wr_tag), .wr_data(wr_data)
    );

    logic unused_hit;
    assign unused_hit = s_hit;
endmodule

// File: rtl/scc_checker.sv
`timescale 1ns/1ps
// Protocol checker for snoop_coherence_ctrl, attached by bind.
module scc_checker
    import scc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_stall_o,
    input logic              cpu_done_o,
    input logic              bus_req_o,
    input logic              bus_gnt_i,
    input logic [1:0]        bus_cmd_o,
    input logic [1:0]        snp_cmd_i,
    input logic [ADDR_W-1:0] snp_addr_i,
    input logic              snp_flush_o
);
    // R9: commands only in granted cycles.
    p_cmd_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_o != CMD_IDLE |-> bus_req_o && bus_gnt_i);

    // R9: a placed miss completes in the following cycle.
    p_miss_then_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o == CMD_RDMISS || bus_cmd_o == CMD_WRMISS) |=> cpu_done_o);

    // R5: a write-back is followed by a fresh request for the miss.
    p_wback_then_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_o == CMD_WBACK |=> bus_req_o && !cpu_done_o);

    // R4: completion never overlaps stall or bus request.
    p_done_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done_o |-> !cpu_stall_o && !bus_req_o);

    // R7: a flush only answers a snooped miss.
    p_flush_on_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush_o |-> (snp_cmd_i == CMD_RDMISS || snp_cmd_i == CMD_WRMISS));

    // R8: after an invalidating flush the same address cannot flush again.
    p_flush_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_flush_o && snp_cmd_i == CMD_WRMISS) |=> !(snp_flush_o && $stable(snp_addr_i)));
endmodule

bind snoop_coherence_ctrl scc_checker #(.ADDR_W(ADDR_W)) u_scc_checker (
    .clk(clk), .rst_n(rst_n), .cpu_stall_o(cpu_stall_o), .cpu_done_o(cpu_done_o),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .bus_cmd_o(bus_cmd_o),
    .snp_cmd_i(snp_cmd_i), .snp_addr_i(snp_addr_i), .snp_flush_o(snp_flush_o)
);

// File: tb/snoop_coherence_ctrl_bench.sv
`timescale 1ns/1ps
// Two caches on one bus with a bench arbiter and memory; table-driven run.
module snoop_coherence_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       req1 = 0, we1 = 0, req2 = 0, we2 = 0, hold1 = 0;
    logic [7:0] addr1 = 0, wd1 = 0, addr2 = 0, wd2 = 0;
    logic       stall1, done1, breq1, gnt1, flush1;
    logic       stall2, done2, breq2, gnt2, flush2;
    logic [7:0] rd1, rd2, baddr1, baddr2, bdata1, bdata2, fill1, fill2, fdata1, fdata2;
    logic [1:0] cmd1, cmd2;
    logic [7:0] mem [256];

    assign gnt1  = breq1 && !hold1;
    assign gnt2  = breq2 && !gnt1;
    assign fill1 = flush2 ? fdata2 : mem[baddr1];
    assign fill2 = flush1 ? fdata1 : mem[baddr2];

    snoop_coherence_ctrl u_snoop_coherence_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req_i(req1), .cpu_we_i(we1), .cpu_addr_i(addr1),
        .cpu_wdata_i(wd1), .cpu_stall_o(stall1), .cpu_done_o(done1), .cpu_rdata_o(rd1),
        .bus_req_o(breq1), .bus_gnt_i(gnt1), .bus_cmd_o(cmd1), .bus_addr_o(baddr1),
        .bus_data_o(bdata1), .bus_fill_i(fill1), .snp_cmd_i(cmd2), .snp_addr_i(baddr2),
        .snp_flush_o(flush1), .snp_data_o(fdata1));

    snoop_coherence_ctrl u_snoop_coherence_ctrl_p2 (
        .clk(clk), .rst_n(rst_n), .cpu_req_i(req2), .cpu_we_i(we2), .cpu_addr_i(addr2),
        .cpu_wdata_i(wd2), .cpu_stall_o(stall2), .cpu_done_o(done2), .cpu_rdata_o(rd2),
        .bus_req_o(breq2), .bus_gnt_i(gnt2), .bus_cmd_o(cmd2), .bus_addr_o(baddr2),
        .bus_data_o(bdata2), .bus_fill_i(fill2), .snp_cmd_i(cmd1), .snp_addr_i(baddr1),
        .snp_flush_o(flush2), .snp_data_o(fdata2));

    // Memory: takes write-backs and flushed words.
    initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    always @(posedge clk) begin
        if (cmd1 == 2'd3) mem[baddr1] <= bdata1;
        if (cmd2 == 2'd3) mem[baddr2] <= bdata2;
        if (flush2) mem[baddr1] <= fdata2;
        if (flush1) mem[baddr2] <= fdata1;
    end

    // Bus log sampled at the falling edge.
    logic [1:0] lg_cmd [4];
    logic [7:0] lg_addr [4];
    logic [7:0] lg_data [4];
    int         lg_n = 0;
    logic       fl_seen = 0;
    logic [7:0] fl_val = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd1 != 2'd0 && lg_n < 4) begin
                lg_cmd[lg_n] = cmd1; lg_addr[lg_n] = baddr1; lg_data[lg_n] = bdata1; lg_n++;
            end
            if (cmd2 != 2'd0 && lg_n < 4) begin
                lg_cmd[lg_n] = cmd2; lg_addr[lg_n] = baddr2; lg_data[lg_n] = bdata2; lg_n++;
            end
            if (flush1) begin fl_seen = 1; fl_val = fdata1; end
            if (flush2) begin fl_seen = 1; fl_val = fdata2; end
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // One processor operation; returns whether it hit and the read word.
    task automatic run_op(input bit p2, input bit we, input logic [7:0] a, input logic [7:0] d,
                          output bit hit, output logic [7:0] rdv);
        int cnt;
        @(posedge clk); #1;
        lg_n = 0; fl_seen = 0;
        if (!p2) begin req1 = 1; we1 = we; addr1 = a; wd1 = d; end
        else     begin req2 = 1; we2 = we; addr2 = a; wd2 = d; end
        @(negedge clk);
        hit = p2 ? (done2 && !stall2) : (done1 && !stall1);
        cnt = 0;
        while (!(p2 ? done2 : done1) && cnt < 50) begin
            @(negedge clk); cnt++;
        end
        chk(cnt < 50, "R9 operation completes", cnt, 50);
        rdv = p2 ? rd2 : rd1;
        @(posedge clk); #1;
        req1 = 0; req2 = 0;
    endtask

    typedef struct packed {
        logic p2; logic we; logic [7:0] addr; logic [7:0] wd; logic hit;
        logic [1:0] ncmd; logic [1:0] c0; logic [7:0] a0; logic [7:0] d0;
        logic [1:0] c1; logic [7:0] a1; logic fl; logic [7:0] fv; logic [7:0] rd;
    } step_t;

    localparam int NSTEP = 14;
    // A1 = 8'h11 and A2 = 8'h15 share line index 1.
    localparam step_t STEPS [NSTEP] = '{
        '{1'b0,1'b1,8'h11,8'h10,1'b0,2'd1,2'd2,8'h11,8'h10,2'd0,8'h00,1'b0,8'h00,8'h00},
        '{1'b0,1'b0,8'h11,8'h00,1'b1,2'd0,2'd0,8'h00,8'h00,2'd0,8'h00,1'b0,8'h00,8'h10},
        '{1'b1,1'b0,8'h11,8'h00,1'b0,2'd1,2'd1,8'h11,8'h00,2'd0,8'h00,1'b1,8'h10,8'h10},
        '{1'b1,1'b1,8'h11,8'h20,1'b0,2'd1,2'd2,8'h11,8'h20,2'd0,8'h00,1'b0,8'h00,8'h00},
        '{1'b1,1'b1,8'h15,8'h40,1'b0,2'd2,2'd3,8'h11,8'h20,2'd2,8'h15,1'b0,8'h00,8'h00},
        '{1'b0,1'b0,8'h11,8'h00,1'b0,2'd1,2'd1,8'h11,8'h00,2'd0,8'h00,1'b0,8'h00,8'h20},
        '{1'b0,1'b0,8'h11,8'h00,1'b1,2'd0,2'd0,8'h00,8'h00,2'd0,8'h00,1'b0,8'h00,8'h20},
        '{1'b1,1'b0,8'h15,8'h00,1'b1,2'd0,2'd0,8'h00,8'h00,2'd0,8'h00,1'b0,8'h00,8'h40},
        '{1'b0,1'b1,8'h11,8'h50,1'b0,2'd1,2'd2,8'h11,8'h50,2'd0,8'h00,1'b0,8'h00,8'h00},
        '{1'b0,1'b0,8'h15,8'h00,1'b0,2'd2,2'd3,8'h11,8'h50,2'd1,8'h15,1'b1,8'h40,8'h40},
        '{1'b1,1'b1,8'h15,8'h60,1'b0,2'd1,2'd2,8'h15,8'h60,2'd0,8'h00,1'b0,8'h00,8'h00},
        '{1'b0,1'b0,8'h15,8'h00,1'b0,2'd1,2'd1,8'h15,8'h00,2'd0,8'h00,1'b1,8'h60,8'h60},
        '{1'b1,1'b0,8'h15,8'h00,1'b1,2'd0,2'd0,8'h00,8'h00,2'd0,8'h00,1'b0,8'h00,8'h60},
        '{1'b0,1'b1,8'h11,8'h77,1'b0,2'd1,2'd2,8'h11,8'h77,2'd0,8'h00,1'b0,8'h00,8'h00}
    };

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #500000;
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit         h;
        logic [7:0] r;
        int         cnt;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: quiet after reset
        chk(!stall1 && !breq1 && cmd1 == 2'd0 && !done1 && !breq2 && cmd2 == 2'd0,
            "R1 idle after reset", {stall1, breq1, cmd1, done1}, 0);

        for (int s = 0; s < NSTEP; s++) begin
            run_op(STEPS[s].p2, STEPS[s].we, STEPS[s].addr, STEPS[s].wd, h, r);
            chk(h == STEPS[s].hit, $sformatf("R2 R3 R4 R6 step %0d hit", s), h, STEPS[s].hit);
            chk(lg_n == int'(STEPS[s].ncmd), $sformatf("R5 R9 step %0d command count", s),
                lg_n, STEPS[s].ncmd);
            if (STEPS[s].ncmd >= 1)
                chk(lg_cmd[0] == STEPS[s].c0 && lg_addr[0] == STEPS[s].a0 && lg_data[0] == STEPS[s].d0,
                    $sformatf("R2 R3 R5 step %0d first command", s),
                    {lg_cmd[0], lg_addr[0], lg_data[0]}, {STEPS[s].c0, STEPS[s].a0, STEPS[s].d0});
            if (STEPS[s].ncmd == 2)
                chk(lg_cmd[1] == STEPS[s].c1 && lg_addr[1] == STEPS[s].a1,
                    $sformatf("R5 step %0d second command", s),
                    {lg_cmd[1], lg_addr[1]}, {STEPS[s].c1, STEPS[s].a1});
            chk(fl_seen == STEPS[s].fl && (!fl_seen || fl_val == STEPS[s].fv),
                $sformatf("R7 R8 step %0d flush", s), {fl_seen, fl_val}, {STEPS[s].fl, STEPS[s].fv});
            if (!STEPS[s].we)
                chk(r == STEPS[s].rd, $sformatf("R11 R4 step %0d read data", s), r, STEPS[s].rd);
        end

        // R10 race: cache 1 holds A1 dirty and waits for the bus to read A2.
        hold1 = 1;
        @(posedge clk); #1;
        req1 = 1; we1 = 0; addr1 = 8'h15;
        repeat (2) @(negedge clk);
        chk(stall1 && breq1 && cmd1 == 2'd0, "R9 waiting request holds off", {stall1, breq1, cmd1}, 6'h30);
        run_op(1'b1, 1'b1, 8'h11, 8'h88, h, r);
        chk(lg_n == 1 && lg_cmd[0] == 2'd2 && lg_addr[0] == 8'h11, "R8 foreign write miss", lg_n, 1);
        chk(fl_seen && fl_val == 8'h77, "R8 dirty copy flushed", fl_val, 8'h77);
        @(posedge clk); #1;
        req1 = 1; lg_n = 0; fl_seen = 0; hold1 = 0;
        cnt = 0;
        @(negedge clk);
        while (!done1 && cnt < 50) begin @(negedge clk); cnt++; end
        r = rd1;
        chk(lg_n == 1 && lg_cmd[0] == 2'd1 && lg_addr[0] == 8'h15,
            "R10 restart issues miss with no stale write-back", {lg_n[3:0], lg_cmd[0]}, 8'h11);
        chk(r == 8'h60, "R11 fill after restart", r, 8'h60);
        @(posedge clk); #1;
        req1 = 0;

        // R8: cache 1 was invalidated, so A1 misses and cache 2 flushes.
        run_op(1'b0, 1'b0, 8'h11, 8'h00, h, r);
        chk(!h && lg_n == 1 && lg_cmd[0] == 2'd1, "R8 invalidated line misses", h, 0);
        chk(fl_seen && r == 8'h88, "R7 read miss served by flush", r, 8'h88);

        // R1: reset again, everything Invalid.
        @(posedge clk); #1 rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        run_op(1'b0, 1'b0, 8'h11, 8'h00, h, r);
        chk(!h && lg_n == 1 && lg_cmd[0] == 2'd1, "R1 access after reset misses", h, 0);
        chk(r == 8'h88, "R11 fill from memory after reset", r, 8'h88);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule